// File: doc/BRIEF.md
# SD Card SPI Command Issuer

This block sends a single command to an SD or MMC card attached over SPI and brings back the card's one-byte R1 answer. A controller loads a 6-bit command index, a 32-bit argument and a flag that marks the command as an application command, then pulses `start`. The block handles the rest in order. It releases chip select for one filler byte and selects the card again. It waits until the card stops signalling busy, then shifts out the six-byte command frame. It polls for the answer and reports it on `resp` with a one-cycle `done`. For an application command it first runs the CMD55 prefix by itself, and it stops early when the prefix is refused.

Byte movement goes through a simple byte port: `byte_req` asks for one exchange of `byte_tx`, and the SPI shifter answers with a `byte_done` pulse that carries the received byte on `byte_rx`. When the frame is complete, chip select stays low. The caller can then clock out the trailing bytes of longer responses, or run a data phase, through the pass-through port. That port reaches the byte port only while the issuer is idle.

Top module: `sd_cmd_issuer`

## Requirements
- R1: A `start` seen while `busy` is low captures `cmd_idx`, `cmd_arg` and `cmd_app`, and `busy` is high in the next cycle. A `start` while busy has no effect. Completion is signalled by `done` high for exactly one cycle, with the answer already on `resp`.
- R2: Frame bytes 1 to 5 are sent in this order: 0x40 OR the 6-bit index, then the argument from bits 31:24 down to bits 7:0.
- R3: The sixth frame byte is 0x95 for index 0, 0x87 for index 8, and 0x01 for any other index.
- R4: Before every frame, one 0xFF filler is exchanged with `cs_n` high. Then `cs_n` goes low and 0xFF bytes are exchanged until a received byte equals 0xFF, after which the frame starts.
- R5: If the card does not return 0xFF within READY_CYCLES clock cycles of selection, the issuer sends no frame, finishes with `resp` = 0xFF, and leaves `cs_n` high.
- R6: With `cmd_app` set, CMD55 with argument 0 is sent first. If its answer is 0x00 or 0x01, the requested command follows with a fresh filler, select and ready wait. Any greater answer ends the run and is returned on `resp`.
- R7: After a frame with index 12, one extra 0xFF byte is exchanged and its received value is discarded, even if its bit 7 is clear.
- R8: The answer is polled with 0xFF bytes, at most POLL_TRIES (10) of them. The first received byte with bit 7 clear is returned. If none arrives, the last byte polled is returned.
- R9: `resp` keeps its value until the next accepted `start`. After a run that reaches the answer poll and ends with `done`, `cs_n` stays low.
- R10: While idle, `pt_req`/`pt_tx` drive the byte port and `pt_done`/`pt_rx` return the exchange with `cs_n` unchanged. While busy, `pt_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_app | input | 1 | Issue CMD55 prefix first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 8 | R1 answer or failure code |
| cs_n | output | 1 | Card chip select, active low |
| byte_req | output | 1 | Request one byte exchange |
| byte_tx | output | 8 | Byte to shift out |
| byte_done | input | 1 | Exchange finished |
| byte_rx | input | 8 | Byte shifted in |
| pt_req | input | 1 | Pass-through exchange request |
| pt_tx | input | 8 | Pass-through byte to send |
| pt_done | output | 1 | Pass-through exchange finished |
| pt_rx | output | 8 | Pass-through received byte |

## Verification
The bench models the card as a script of bytes it returns and compares every exchanged byte, together with the chip-select level, against the stream that the requirements predict.

It targets the following corner cases:
- A card that stays busy for several bytes. A design that did not wait would send the frame early.
- A card that never becomes ready. A wrong design would send a frame or leave the card selected instead of returning 0xFF.
- A CMD12 whose stuff slot carries a valid-looking 0x05. A design without the skip would return 0x05.
- A poll that never sees bit 7 clear. A design with the wrong bound would send more or fewer than ten polls.
- A refused CMD55. A wrong design would go on to send the second frame.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int READY_CYCLES = 25_000_000,
  parameter int POLL_TRIES   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        cmd_app,
  output logic        busy,
  output logic        done,
  output logic [7:0]  resp,
  output logic        cs_n,
  output logic        byte_req,
  output logic [7:0]  byte_tx,
  input  logic        byte_done,
  input  logic [7:0]  byte_rx,
  input  logic        pt_req,
  input  logic [7:0]  pt_tx,
  output logic        pt_done,
  output logic [7:0]  pt_rx
);
  localparam int TW = $clog2(READY_CYCLES + 1);
  localparam int PW = $clog2(POLL_TRIES + 1);
  localparam int CW = (PW > 3) ? PW : 3;
  localparam logic [TW-1:0] T_LIM = TW'(READY_CYCLES);
  localparam logic [CW-1:0] P_LAST = CW'(POLL_TRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_DESEL, S_READY, S_FRAME, S_STUFF, S_RESP} st_t;

  st_t           st;
  logic [5:0]    idx_q;
  logic [31:0]   arg_q;
  logic          prefix;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic [7:0]    resp_q;
  logic          cs_n_q;
  logic          done_q;

  logic [5:0]  cur_idx;
  logic [31:0] cur_arg;
  logic [7:0]  crc_byte;
  logic [7:0]  frame_byte;

  assign cur_idx  = prefix ? 6'd55 : idx_q;
  assign cur_arg  = prefix ? 32'd0 : arg_q;
  assign crc_byte = (cur_idx == 6'd0) ? 8'h95 : (cur_idx == 6'd8) ? 8'h87 : 8'h01;

  always_comb begin
    case (cnt)
      CW'(0):  frame_byte = {2'b01, cur_idx};
      CW'(1):  frame_byte = cur_arg[31:24];
      CW'(2):  frame_byte = cur_arg[23:16];
      CW'(3):  frame_byte = cur_arg[15:8];
      CW'(4):  frame_byte = cur_arg[7:0];
      default: frame_byte = crc_byte;
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign resp     = resp_q;
  assign cs_n     = cs_n_q;
  assign byte_req = busy | pt_req;
  assign byte_tx  = (st == S_FRAME) ? frame_byte : (busy ? 8'hFF : pt_tx);
  assign pt_done  = byte_done & ~busy;
  assign pt_rx    = byte_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx_q  <= '0;
      arg_q  <= '0;
      prefix <= 1'b0;
      cnt    <= '0;
      tmr    <= '0;
      resp_q <= '0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx_q  <= cmd_idx;
          arg_q  <= cmd_arg;
          prefix <= cmd_app;
          cs_n_q <= 1'b1;
          st     <= S_DESEL;
        end
        S_DESEL: if (byte_done) begin
          cs_n_q <= 1'b0;
          tmr    <= '0;
          st     <= S_READY;
        end
        S_READY: begin
          if (tmr < T_LIM) tmr <= tmr + 1'b1;
          if (byte_done) begin
            if (byte_rx == 8'hFF) begin
              cnt <= '0;
              st  <= S_FRAME;
            end else if (tmr >= T_LIM) begin
              resp_q <= 8'hFF;
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
        S_FRAME: if (byte_done) begin
          if (cnt == CW'(5)) begin
            cnt <= '0;
            st  <= (cur_idx == 6'd12) ? S_STUFF : S_RESP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STUFF: if (byte_done) st <= S_RESP;
        S_RESP: if (byte_done) begin
          if (!byte_rx[7] || cnt == P_LAST) begin
            if (prefix && byte_rx <= 8'h01) begin
              prefix <= 1'b0;
              cs_n_q <= 1'b1;
              st     <= S_DESEL;
            end else begin
              resp_q <= byte_rx;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_issuer_chk.sv
module sd_cmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [7:0] resp,
  input logic       cs_n,
  input logic       byte_req,
  input logic [7:0] byte_tx,
  input logic       byte_done
);
  a_r1_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(resp));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_req && !byte_done) |=> byte_req);

  a_r2_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_req && !byte_done) |=> $stable(byte_tx));

  a_r4_cs_between_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && byte_req && !byte_done) |=> $stable(cs_n));
endmodule

bind sd_cmd_issuer sd_cmd_issuer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .resp(resp), .cs_n(cs_n), .byte_req(byte_req), .byte_tx(byte_tx),
  .byte_done(byte_done)
);

// File: tb/sd_cmd_issuer_tb_top.sv
module sd_cmd_issuer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        cmd_app = 1'b0;
  logic        busy, done, cs_n, byte_req, pt_done;
  logic [7:0]  resp, byte_tx, pt_rx;
  logic        byte_done;
  logic [7:0]  byte_rx;
  logic        pt_req = 1'b0;
  logic [7:0]  pt_tx = '0;

  always #10 clk = ~clk;

  sd_cmd_issuer #(.READY_CYCLES(200), .POLL_TRIES(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .cmd_app(cmd_app), .busy(busy), .done(done), .resp(resp), .cs_n(cs_n),
    .byte_req(byte_req), .byte_tx(byte_tx), .byte_done(byte_done), .byte_rx(byte_rx),
    .pt_req(pt_req), .pt_tx(pt_tx), .pt_done(pt_done), .pt_rx(pt_rx)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R4";
  bit ff_only = 1'b0;
  logic [7:0] rx_script[$];
  logic [8:0] exp_tx[$];
  logic [7:0] exp_resp[$];

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endfunction

  // card-side byte engine
  logic       eng_act;
  int         eng_cnt;
  logic [7:0] eng_tx;
  always @(posedge clk) begin
    if (!rst_n) begin
      eng_act   <= 1'b0;
      eng_cnt   <= 0;
      eng_tx    <= '0;
      byte_done <= 1'b0;
      byte_rx   <= 8'hFF;
    end else begin
      byte_done <= 1'b0;
      if (eng_act) begin
        if (eng_cnt == 0) begin
          eng_act   <= 1'b0;
          byte_done <= 1'b1;
          byte_rx   <= (rx_script.size() != 0) ? rx_script.pop_front() : 8'hFF;
        end else eng_cnt <= eng_cnt - 1;
      end else if (!byte_done && byte_req) begin
        eng_act <= 1'b1;
        eng_cnt <= 2;
        eng_tx  <= byte_tx;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && byte_done) begin
      if (ff_only) chk(eng_tx == 8'hFF, "R5", {24'd0, eng_tx}, 32'hFF);
      else if (exp_tx.size() == 0) chk(1'b0, cur_req, {23'd0, cs_n, eng_tx}, 32'h0);
      else begin
        logic [8:0] e;
        e = exp_tx.pop_front();
        chk({cs_n, eng_tx} == e, cur_req, {23'd0, cs_n, eng_tx}, {23'd0, e});
      end
    end
    if (rst_n && done) begin
      if (exp_resp.size() == 0) chk(1'b0, "R1", {24'd0, resp}, 32'h0);
      else begin
        logic [7:0] r;
        r = exp_resp.pop_front();
        chk(resp == r, cur_req, {24'd0, resp}, {24'd0, r});
      end
    end
    if (rst_n && busy && pt_done) chk(1'b0, "R10", 32'd1, 32'd0);
  end

  task automatic seg(input logic [5:0] idx, input logic [31:0] arg, input int nbusy,
                     input int mff, input logic [7:0] r, input bit stuff, input logic [7:0] sval);
    logic [7:0] crc;
    crc = (idx == 0) ? 8'h95 : (idx == 8) ? 8'h87 : 8'h01;
    rx_script.push_back(8'hFF);
    exp_tx.push_back({1'b1, 8'hFF});
    for (int i = 0; i < nbusy; i++) begin
      rx_script.push_back(8'h00);
      exp_tx.push_back({1'b0, 8'hFF});
    end
    rx_script.push_back(8'hFF);
    exp_tx.push_back({1'b0, 8'hFF});
    exp_tx.push_back({1'b0, 2'b01, idx});
    exp_tx.push_back({1'b0, arg[31:24]});
    exp_tx.push_back({1'b0, arg[23:16]});
    exp_tx.push_back({1'b0, arg[15:8]});
    exp_tx.push_back({1'b0, arg[7:0]});
    exp_tx.push_back({1'b0, crc});
    for (int i = 0; i < 6; i++) rx_script.push_back(8'hFF);
    if (stuff) begin
      rx_script.push_back(sval);
      exp_tx.push_back({1'b0, 8'hFF});
    end
    for (int i = 0; i < mff; i++) begin
      rx_script.push_back(8'hFF);
      exp_tx.push_back({1'b0, 8'hFF});
    end
    rx_script.push_back(r);
    exp_tx.push_back({1'b0, 8'hFF});
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit app,
                         input logic [7:0] r, input bit poke);
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; cmd_app = app; start = 1'b1;
    exp_resp.push_back(r);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      cmd_idx = 6'd24; cmd_arg = 32'hDEADBEEF; cmd_app = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(exp_tx.size() == 0, cur_req, exp_tx.size(), 32'd0);
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && busy == 1'b0 && done == 1'b0 && byte_req == 1'b0, "R1",
        {29'd0, cs_n, busy, byte_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R3";   // CMD0: 40 00 00 00 00 95
    seg(6'd0, 32'd0, 0, 1, 8'h01, 0, 8'h00);
    run_cmd(6'd0, 32'd0, 0, 8'h01, 0);

    cur_req = "R4";   // CMD8 with two busy bytes, crc 87
    seg(6'd8, 32'h000001AA, 2, 2, 8'h01, 0, 8'h00);
    run_cmd(6'd8, 32'h000001AA, 0, 8'h01, 0);

    cur_req = "R2";   // argument MSB first, dummy crc; start while busy ignored (R1)
    seg(6'd17, 32'h12345678, 0, 0, 8'h00, 0, 8'h00);
    run_cmd(6'd17, 32'h12345678, 0, 8'h00, 1);

    held = resp;      // R9: answer held, card still selected
    repeat (20) @(negedge clk);
    chk(resp == held, "R9", {24'd0, resp}, {24'd0, held});
    chk(cs_n == 1'b0, "R9", {31'd0, cs_n}, 32'd0);

    cur_req = "R7";   // stuff byte 05 must be skipped
    seg(6'd12, 32'd0, 0, 1, 8'h00, 1, 8'h05);
    run_cmd(6'd12, 32'd0, 0, 8'h00, 0);

    cur_req = "R8";   // ten polls, none valid: last byte 83 returned
    seg(6'd16, 32'd512, 0, 9, 8'h83, 0, 8'h00);
    run_cmd(6'd16, 32'd512, 0, 8'h83, 0);

    cur_req = "R6";   // CMD55 answered 01, then ACMD41
    seg(6'd55, 32'd0, 0, 0, 8'h01, 0, 8'h00);
    seg(6'd41, 32'h40000000, 1, 2, 8'h00, 0, 8'h00);
    run_cmd(6'd41, 32'h40000000, 1, 8'h00, 0);

    cur_req = "R6";   // CMD55 refused with 05: no second frame
    seg(6'd55, 32'd0, 0, 1, 8'h05, 0, 8'h00);
    run_cmd(6'd41, 32'd0, 1, 8'h05, 0);

    cur_req = "R10";  // pass-through while idle
    rx_script.push_back(8'hA5);
    exp_tx.push_back({1'b0, 8'h5A});
    @(negedge clk);
    pt_tx = 8'h5A; pt_req = 1'b1;
    while (!pt_done) @(negedge clk);
    chk(pt_rx == 8'hA5, "R10", {24'd0, pt_rx}, 32'hA5);
    pt_req = 1'b0;
    repeat (8) @(negedge clk);
    chk(exp_tx.size() == 0 && cs_n == 1'b0, "R10", {31'd0, cs_n}, 32'd0);

    cur_req = "R5";   // card never ready
    ff_only = 1'b1;
    rx_script.push_back(8'hFF);
    for (int i = 0; i < 80; i++) rx_script.push_back(8'h00);
    run_cmd(6'd17, 32'd0, 0, 8'hFF, 0);
    chk(cs_n == 1'b1, "R5", {31'd0, cs_n}, 32'd1);
    ff_only = 1'b0;
    rx_script.delete();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule